// File: doc/BRIEF.md
# Register-Immediate Integer Execute Stage

This block is the purely combinational execute stage for the 64-bit integer operations that take one register operand and an immediate. It decodes a 32-bit instruction word on its own, takes the first source operand, and in the same cycle returns the value for the destination register, a write enable and a flag for encodings it must not execute.

Three instruction groups are handled. The full-width immediate group covers add, set-less-than (signed and unsigned), xor, or, and, and the three shifts. The 32-bit word group covers add-word and the three word shifts. Load-upper-immediate is the third. The word group reads only the low half of the operand and returns a 32-bit result sign-extended to 64 bits.

When an encoding is reserved or not recognised, the block raises the flag and holds the write enable low. The pipeline around it decides what to do with the flag.

Top module: `imm_exec_unit`

## Requirements
- R1: Opcode 7'b0010011 with funct3 000 (add), 100 (xor), 110 (or) or 111 (and) combines rs1 with the immediate sign-extended from instruction bits 31:20, over the full 64 bits. Add ignores overflow.
- R2: Opcode 7'b0010011 with funct3 010 compares rs1 with the sign-extended immediate as signed numbers, and funct3 011 compares them as unsigned numbers. The result is 1 when rs1 is smaller and 0 otherwise.
- R3: Opcode 7'b0010011 with funct3 001 is a left shift that fills with zeros, and funct3 101 is a right shift. Both take a 6-bit amount from instruction bits 25:20. For the right shift, bits 31:26 = 000000 fills with zeros and 010000 fills with copies of bit 63. Any other pattern in bits 31:26 is flagged, and 010000 is also flagged for the left shift.
- R4: Opcode 7'b0011011 with funct3 000 adds the sign-extended immediate to rs1[31:0]. The result is the low 32 bits of the sum, sign-extended to 64 bits, and rs1[63:32] has no effect.
- R5: Opcode 7'b0011011 with funct3 001 (left) or 101 (right) shifts rs1[31:0] by the 5-bit amount in instruction bits 24:20. Bits 31:25 = 0100000 selects an arithmetic right shift that fills with copies of bit 31 of the operand. The 32-bit result is sign-extended to 64 bits.
- R6: A word shift with instruction bit 25 set is reserved. It is flagged and not executed.
- R7: Opcode 7'b0110111 places instruction bits 31:12 into result bits 31:12, zeros into bits 11:0, and sign-extends the result from bit 31.
- R8: Any opcode other than the three above is flagged. Opcode 7'b0011011 with a funct3 other than 000, 001 or 101 is also flagged.
- R9: A flagged encoding drives the write enable low and the result to zero. Every other encoding drives the write enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word; opcode in bits 6:0, funct3 in bits 14:12 |
| rs1_i | input | 64 | First source operand |
| result_o | output | 64 | Value for the destination register |
| wr_en_o | output | 1 | Destination write enable |
| rsvd_o | output | 1 | Encoding reserved or not recognised |

## Verification
Checks run whenever the inputs change. They cover:
- an unknown opcode or a reserved word-shift pattern always raises the flag;
- a flagged encoding leaves the result at zero with no write;
- set-less-than returns only 0 or 1;
- load-upper-immediate clears the low twelve bits;
- every executed word operation returns a properly sign-extended value.

Only the bench's scenarios can show the actual arithmetic values. These include:
- shift fill at the 0x80000000 and 0x7FFFFFFF boundaries;
- the signed and unsigned comparisons against an all-ones immediate;
- rs1[63:32] having no effect on the word operations.

A randomized run compares every operation against a behavioural model.

// File: rtl/imm_exec_pkg.sv
// Shared encodings and operation codes for the immediate execute stage.
// Assumes the standard 32-bit instruction layout: opcode in bits 6:0,
// funct3 in bits 14:12, immediate in the top bits.
package imm_exec_pkg;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_IMM32 = 7'b0011011;
    localparam logic [6:0] OPC_LUI   = 7'b0110111;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SLT,
        ALU_SLTU,
        ALU_XOR,
        ALU_OR,
        ALU_AND,
        ALU_SLL,
        ALU_SRL,
        ALU_SRA,
        ALU_PASS
    } alu_op_e;
endpackage

// File: rtl/imm_exec_decode.sv
// Instruction decoder for the immediate execute stage.
// Produces the operation, the immediate operand, the shift amount, the
// word-mode select and the reserved flag. Assumes XLEN >= 64.
module imm_exec_decode
    import imm_exec_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [31:0]     instr_i,
    output alu_op_e         op_o,
    output logic [XLEN-1:0] imm_o,
    output logic [SHW-1:0]  shamt_o,
    output logic            word_o,
    output logic            bad_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [5:0] hi6;
    logic [6:0] hi7;
    logic       unused_rd;

    assign opc       = instr_i[6:0];
    assign f3        = instr_i[14:12];
    assign hi6       = instr_i[31:26];
    assign hi7       = instr_i[31:25];
    assign unused_rd = ^instr_i[11:7];
    assign shamt_o   = instr_i[20 +: SHW];

    // Decode opcode, funct3 and the upper immediate bits into an operation
    always_comb begin
        op_o   = ALU_ADD;
        word_o = 1'b0;
        bad_o  = 1'b0;
        imm_o  = {{(XLEN-12){instr_i[31]}}, instr_i[31:20]};
        case (opc)
            OPC_IMM: begin
                case (f3)
                    3'b000: op_o = ALU_ADD;
                    3'b010: op_o = ALU_SLT;
                    3'b011: op_o = ALU_SLTU;
                    3'b100: op_o = ALU_XOR;
                    3'b110: op_o = ALU_OR;
                    3'b111: op_o = ALU_AND;
                    3'b001: begin
                        op_o  = ALU_SLL;
                        bad_o = (hi6 != 6'b000000);
                    end
                    default: begin
                        op_o  = instr_i[30] ? ALU_SRA : ALU_SRL;
                        bad_o = (hi6 != 6'b000000) && (hi6 != 6'b010000);
                    end
                endcase
            end
            OPC_IMM32: begin
                word_o = 1'b1;
                case (f3)
                    3'b000: op_o = ALU_ADD;
                    3'b001: begin
                        op_o  = ALU_SLL;
                        bad_o = (hi7 != 7'b0000000);
                    end
                    3'b101: begin
                        op_o  = instr_i[30] ? ALU_SRA : ALU_SRL;
                        bad_o = (hi7 != 7'b0000000) && (hi7 != 7'b0100000);
                    end
                    default: bad_o = 1'b1;
                endcase
            end
            OPC_LUI: begin
                op_o  = ALU_PASS;
                imm_o = {{(XLEN-32){instr_i[31]}}, instr_i[31:12], 12'b0};
            end
            default: bad_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/imm_exec_alu.sv
// Width-generic arithmetic/logic unit for one operand and an immediate.
// Used once at full width and once at word width. Assumes W is a power of two.
module imm_exec_alu
    import imm_exec_pkg::*;
#(
    parameter int W   = 64,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [SHW-1:0] shamt_i,
    input  alu_op_e        op_i,
    output logic [W-1:0]   res_o
);
    logic lt_s;
    logic lt_u;

    assign lt_s = $signed(a_i) < $signed(b_i);
    assign lt_u = a_i < b_i;

    // Select the operation result
    always_comb begin
        case (op_i)
            ALU_ADD:  res_o = a_i + b_i;
            ALU_SLT:  res_o = {{(W-1){1'b0}}, lt_s};
            ALU_SLTU: res_o = {{(W-1){1'b0}}, lt_u};
            ALU_XOR:  res_o = a_i ^ b_i;
            ALU_OR:   res_o = a_i | b_i;
            ALU_AND:  res_o = a_i & b_i;
            ALU_SLL:  res_o = a_i << shamt_i;
            ALU_SRL:  res_o = a_i >> shamt_i;
            ALU_SRA:  res_o = $signed(a_i) >>> shamt_i;
            default:  res_o = b_i;
        endcase
    end
endmodule

// File: rtl/imm_exec_unit.sv
// Top of the immediate execute stage: decoder, a full-width ALU and a
// word-width ALU, then result selection with sign extension. Purely
// combinational; the surrounding pipeline registers the outputs.
module imm_exec_unit
    import imm_exec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] rs1_i,
    output logic [XLEN-1:0] result_o,
    output logic            wr_en_o,
    output logic            rsvd_o
);
    localparam int WLEN = 32;
    localparam int SHW  = $clog2(XLEN);
    localparam int WSHW = $clog2(WLEN);

    alu_op_e         op;
    logic [XLEN-1:0] imm;
    logic [SHW-1:0]  shamt;
    logic            word;
    logic            bad;
    logic [XLEN-1:0] full_res;
    logic [WLEN-1:0] word_res;

    imm_exec_decode #(.XLEN(XLEN), .SHW(SHW)) u_dec (
        .instr_i (instr_i),
        .op_o    (op),
        .imm_o   (imm),
        .shamt_o (shamt),
        .word_o  (word),
        .bad_o   (bad)
    );

    imm_exec_alu #(.W(XLEN), .SHW(SHW)) u_alu_full (
        .a_i     (rs1_i),
        .b_i     (imm),
        .shamt_i (shamt),
        .op_i    (op),
        .res_o   (full_res)
    );

    imm_exec_alu #(.W(WLEN), .SHW(WSHW)) u_alu_word (
        .a_i     (rs1_i[WLEN-1:0]),
        .b_i     (imm[WLEN-1:0]),
        .shamt_i (shamt[WSHW-1:0]),
        .op_i    (op),
        .res_o   (word_res)
    );

    // Pick the lane, sign-extend word results, and quiet flagged encodings
    always_comb begin
        rsvd_o  = bad;
        wr_en_o = !bad;
        if (bad)
            result_o = '0;
        else if (word)
            result_o = {{(XLEN-WLEN){word_res[WLEN-1]}}, word_res};
        else
            result_o = full_res;
    end

    // Checks on the port behaviour
    always_comb begin
        // R8
        unknown_opc_chk: assert (((instr_i[6:0] == OPC_IMM) || (instr_i[6:0] == OPC_IMM32) ||
                                  (instr_i[6:0] == OPC_LUI)) || rsvd_o);
        // R6
        word_shift_rsvd_chk: assert (!((instr_i[6:0] == OPC_IMM32) && instr_i[25] &&
                                       ((instr_i[14:12] == 3'b001) || (instr_i[14:12] == 3'b101))) || rsvd_o);
        // R9
        rsvd_quiet_chk: assert (!rsvd_o || (!wr_en_o && (result_o == '0)));
        // R2
        slt_bool_chk: assert (!((op == ALU_SLT || op == ALU_SLTU) && !word && wr_en_o) ||
                              (result_o[XLEN-1:1] == '0));
        // R7
        lui_low_zero_chk: assert (!(instr_i[6:0] == OPC_LUI) || (wr_en_o && (result_o[11:0] == 12'b0)));
        // R4
        word_sext_chk: assert (!(word && wr_en_o) ||
                               (result_o[XLEN-1:WLEN-1] == '0) || (&result_o[XLEN-1:WLEN-1]));
    end
endmodule

// File: tb/sim_imm_exec_unit.sv
module sim_imm_exec_unit;
    localparam int  N_VEC  = 19;
    localparam int  N_RAND = 600;
    localparam real TCLK   = 10.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr;
    logic [63:0] rs1;
    logic [63:0] result;
    logic        wr_en;
    logic        rsvd;
    int          n_chk = 0;
    int          n_err = 0;

    always #(TCLK/2) clk = ~clk;

    imm_exec_unit u0 (
        .instr_i  (instr),
        .rs1_i    (rs1),
        .result_o (result),
        .wr_en_o  (wr_en),
        .rsvd_o   (rsvd)
    );

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3, input logic [6:0] opc);
        return {imm, 5'd1, f3, 5'd2, opc};
    endfunction

    function automatic logic [31:0] enc_u(input logic [19:0] imm);
        return {imm, 5'd2, 7'b0110111};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [63:0] a;
        logic [63:0] exp;
        logic        bad;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VEC [N_VEC] = '{
        // R1 add with negative immediate, and with all-ones masks
        '{enc_i(12'hFFF, 3'b000, 7'b0010011), 64'd5, 64'd4, 1'b0, 8'd1},
        '{enc_i(12'h800, 3'b111, 7'b0010011), 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFF800, 1'b0, 8'd1},
        '{enc_i(12'h7FF, 3'b100, 7'b0010011), 64'h000000000000FFFF, 64'h000000000000F800, 1'b0, 8'd1},
        // R2 signed versus unsigned against all-ones
        '{enc_i(12'hFFF, 3'b010, 7'b0010011), 64'd0, 64'd0, 1'b0, 8'd2},
        '{enc_i(12'hFFF, 3'b011, 7'b0010011), 64'd0, 64'd1, 1'b0, 8'd2},
        '{enc_i(12'h000, 3'b010, 7'b0010011), 64'h8000000000000000, 64'd1, 1'b0, 8'd2},
        // R3 full-width shifts
        '{enc_i(12'h43F, 3'b101, 7'b0010011), 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 1'b0, 8'd3},
        '{enc_i(12'h020, 3'b101, 7'b0010011), 64'h8000000000000000, 64'h0000000080000000, 1'b0, 8'd3},
        '{enc_i(12'h401, 3'b001, 7'b0010011), 64'd1, 64'd0, 1'b1, 8'd3},
        // R4 word add overflow, upper operand half set
        '{enc_i(12'h001, 3'b000, 7'b0011011), 64'hDEADBEEF7FFFFFFF, 64'hFFFFFFFF80000000, 1'b0, 8'd4},
        // R5 word shifts
        '{enc_i(12'h404, 3'b101, 7'b0011011), 64'h0000000080000000, 64'hFFFFFFFFF8000000, 1'b0, 8'd5},
        '{enc_i(12'h001, 3'b101, 7'b0011011), 64'hFFFFFFFF80000000, 64'h0000000040000000, 1'b0, 8'd5},
        '{enc_i(12'h01F, 3'b001, 7'b0011011), 64'd1, 64'hFFFFFFFF80000000, 1'b0, 8'd5},
        // R6 word shifts with amount bit 5 set
        '{enc_i(12'h020, 3'b001, 7'b0011011), 64'd1, 64'd0, 1'b1, 8'd6},
        '{enc_i(12'h420, 3'b101, 7'b0011011), 64'd1, 64'd0, 1'b1, 8'd6},
        // R7 load-upper with and without sign
        '{enc_u(20'h80000), 64'd0, 64'hFFFFFFFF80000000, 1'b0, 8'd7},
        '{enc_u(20'h12345), 64'hFFFF, 64'h0000000012345000, 1'b0, 8'd7},
        // R8 bad word funct3, unknown opcode
        '{enc_i(12'h000, 3'b010, 7'b0011011), 64'd3, 64'd0, 1'b1, 8'd8},
        '{enc_i(12'h000, 3'b000, 7'b0110011), 64'd3, 64'd0, 1'b1, 8'd8}
    };

    // Behavioural model written from the requirements
    function automatic void ref_model(input logic [31:0] ins, input logic [63:0] a,
                                      output logic [63:0] r, output logic bad);
        logic [63:0] imm;
        logic [31:0] w;
        imm = {{52{ins[31]}}, ins[31:20]};
        bad = 1'b0;
        r   = '0;
        w   = '0;
        case (ins[6:0])
            7'b0010011: case (ins[14:12])
                3'b000: r = a + imm;
                3'b010: r = ($signed(a) < $signed(imm)) ? 64'd1 : 64'd0;
                3'b011: r = (a < imm) ? 64'd1 : 64'd0;
                3'b100: r = a ^ imm;
                3'b110: r = a | imm;
                3'b111: r = a & imm;
                3'b001: if (ins[31:26] != 6'b0) bad = 1'b1; else r = a << ins[25:20];
                default: begin
                    if (ins[31:26] == 6'b0) r = a >> ins[25:20];
                    else if (ins[31:26] == 6'b010000) r = $signed(a) >>> ins[25:20];
                    else bad = 1'b1;
                end
            endcase
            7'b0011011: begin
                case (ins[14:12])
                    3'b000: w = a[31:0] + imm[31:0];
                    3'b001: if (ins[31:25] != 7'b0) bad = 1'b1; else w = a[31:0] << ins[24:20];
                    3'b101: begin
                        if (ins[31:25] == 7'b0) w = a[31:0] >> ins[24:20];
                        else if (ins[31:25] == 7'b0100000) w = $signed(a[31:0]) >>> ins[24:20];
                        else bad = 1'b1;
                    end
                    default: bad = 1'b1;
                endcase
                r = {{32{w[31]}}, w};
            end
            7'b0110111: r = {{32{ins[31]}}, ins[31:12], 12'b0};
            default: bad = 1'b1;
        endcase
        if (bad) r = '0;
    endfunction

    task automatic apply(input logic [31:0] ins, input logic [63:0] a);
        @(negedge clk);
        instr = ins;
        rs1   = a;
        #1;
    endtask

    task automatic check(input int req, input logic [63:0] exp, input logic exp_bad);
        n_chk++;
        if (result !== exp || rsvd !== exp_bad || wr_en !== !exp_bad) begin
            n_err++;
            $display("FAIL R%0d: instr=%h rs1=%h got res=%h rsvd=%b we=%b expected res=%h rsvd=%b we=%b",
                     req, instr, rs1, result, rsvd, wr_en, exp, exp_bad, !exp_bad);
        end
    endtask

    initial begin
        #(TCLK * 150000);
        n_err++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [63:0] er;
        logic        eb;
        logic [63:0] corners [6];
        instr = '0;
        rs1   = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle word is all zeros: unknown opcode, R8 and R9
        apply(32'h0, 64'hFFFFFFFFFFFFFFFF);
        check(9, 64'd0, 1'b1);

        // Vector table (R1 to R8; R9 on every entry via write enable)
        for (int i = 0; i < N_VEC; i++) begin
            apply(VEC[i].ins, VEC[i].a);
            check(int'(VEC[i].req), VEC[i].exp, VEC[i].bad);
        end

        // R4: the upper operand half has no effect on a word add
        apply(enc_i(12'h7FF, 3'b000, 7'b0011011), 64'h0000000000000001);
        check(4, 64'h0000000000000800, 1'b0);
        apply(enc_i(12'h7FF, 3'b000, 7'b0011011), 64'hFFFFFFFF00000001);
        check(4, 64'h0000000000000800, 1'b0);

        // R5: arithmetic word shift of a positive boundary value
        apply(enc_i(12'h41F, 3'b101, 7'b0011011), 64'hFFFFFFFF7FFFFFFF);
        check(5, 64'd0, 1'b0);

        // R1 R2 R3 R4 R5 R6 R7 R8 R9 randomized against the model
        corners = '{64'h0, 64'h80000000, 64'h7FFFFFFF, 64'hFFFFFFFFFFFFFFFF,
                    64'h8000000000000000, 64'hFFFFFFFF80000000};
        for (int k = 0; k < N_RAND; k++) begin
            logic [31:0] ins;
            logic [63:0] a;
            logic [1:0]  sel;
            ins = $urandom;
            sel = 2'($urandom % 4);
            case (sel)
                2'd0: ins[6:0] = 7'b0010011;
                2'd1: ins[6:0] = 7'b0011011;
                2'd2: ins[6:0] = 7'b0110111;
                default: ;
            endcase
            if ($urandom % 2 == 0) ins[29:25] = 5'b0;
            if ($urandom % 2 == 0) ins[31] = 1'b0;
            if ($urandom % 3 == 0) a = corners[$urandom % 6];
            else a = {$urandom, $urandom};
            apply(ins, a);
            ref_model(ins, a, er, eb);
            check(0, er, eb);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule